// File: doc/BRIEF.md
# Segment Access Limit and Rights Checker

This block checks one memory access that goes through a segment descriptor already held in a cache. It also works out the linear address for that access. Each request carries the following fields:

- the cached descriptor: a 32-bit base, a 20-bit limit field, a granularity flag, a default-size flag and an 8-bit rights byte;
- a 32-bit offset;
- an access kind: read, write or instruction fetch.

One cycle after a request is accepted, the block presents its result. The result is either the linear address (base plus offset) or a fault with a two-bit cause: not-present, type or limit.

Both the request side and the result side use valid/ready handshakes, and the output stage holds one result. The block takes a request when `in_valid` and `in_ready` are both high on a rising edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The block keeps a result on its outputs, unchanged, until `out_ready` is high on an edge while `out_valid` is high. As a result, a stalled consumer stops new requests with no loss and no repeat. The rest of the pipeline can therefore treat the checker as a single register stage.

The rights byte uses these fields. Bit 7 is present. Bits 6:5 are the privilege level and are ignored here. Bit 4 is set for a code, data or stack descriptor and clear for a system descriptor. Bits 3:1 are the 3-bit type. Bit 0 is the accessed flag and is ignored.

The access kind is encoded as 0 = read, 1 = write, 2 = fetch and 3 = reserved.

The cause is encoded as 0 = none, 1 = not-present, 2 = type and 3 = limit.

Top module: `seg_access_check`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A request accepted on an edge gives `out_valid` = 1 after that edge. A reset clears `out_valid` to 0.
- R2: While `out_valid` = 1 and `out_ready` = 0, the outputs `out_valid`, `out_fault`, `out_cause` and `out_lin_addr` stay unchanged, and `in_ready` is 0.
- R3: When the granularity flag is 0, the byte limit equals the 20-bit limit field. For a segment that is not expand-down, an offset above the byte limit gives cause 3 (limit), and an offset equal to it is accepted.
- R4: When the granularity flag is 1, the byte limit is the limit field shifted left by 12 with the low 12 bits set to ones. For example, field 0x00001 gives a byte limit of 0x1FFF.
- R5: Types 2 and 3 are expand-down. An offset is accepted only if it is strictly above the byte limit and no higher than the top of the segment. The top is 0xFFFF when the default-size flag is 0 and 0xFFFFFFFF when it is 1. Any other offset gives cause 3.
- R6: A write gives cause 2 (type) for code types 4 to 7 and for the read-only types 0 and 2.
- R7: A read gives cause 2 for types 4 and 6. A fetch gives cause 2 for types 0 to 3.
- R8: A rights byte with bit 7 = 0 gives cause 1 (not-present), whatever the kind, type or offset.
- R9: A present descriptor with bit 4 = 0 (system) gives cause 2 for every access kind. A reserved kind (3) also gives cause 2.
- R10: When more than one fault applies, the reported cause is not-present first, then type, then limit.
- R11: When there is no fault, `out_lin_addr` is (base + offset) mod 2^32 and `out_fault` = 0. When there is a fault, `out_fault` = 1, `out_cause` is not 0 and `out_lin_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The block can take a request |
| in_base | input | 32 | Descriptor base address |
| in_limit | input | 20 | Descriptor limit field |
| in_gran | input | 1 | Granularity flag (1 = units of 4 KB) |
| in_big | input | 1 | Default-size flag (1 = 32-bit stack top) |
| in_rights | input | 8 | Rights byte: present, privilege level, kind, type, accessed |
| in_offset | input | 32 | Offset inside the segment |
| in_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the result |
| out_fault | output | 1 | The access is refused |
| out_cause | output | 2 | Fault cause: 0 none, 1 not-present, 2 type, 3 limit |
| out_lin_addr | output | 32 | Linear address, or 0 on a fault |

## Verification
The handshake assertions assume that the request fields are sampled only on an edge where `in_valid` and `in_ready` are both high. They also assume that `out_ready` may change freely. The bench drives every input on the falling edge, so the values are settled at the edge that samples them.

The decode assertions assume the bit positions given above for the rights byte and the access kind. The stimulus uses only rights bytes built from those fields.

Reset is held for several cycles before the first request, so no property sees an undefined request.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_ABSENT  = 2'd1,
    CAUSE_TYPE    = 2'd2,
    CAUSE_LIMIT   = 2'd3
  } cause_e;

  // bit positions inside the rights byte
  localparam int RB_PRESENT = 7;
  localparam int RB_NONSYS  = 4;
  localparam int RB_TYPE_HI = 3;
  localparam int RB_TYPE_LO = 1;

endpackage

// File: rtl/seg_rights_eval.sv
module seg_rights_eval
  import seg_chk_pkg::*;
(
  input  logic [7:0] rights,
  input  logic [1:0] kind,
  output logic       absent,
  output logic       type_bad,
  output logic       expand_down
);

  logic [2:0] seg_type;
  logic       is_code;
  logic       writable_data;
  logic       readable_code;
  acc_kind_e  acc;

  always_comb begin
    seg_type      = rights[RB_TYPE_HI:RB_TYPE_LO];
    acc           = acc_kind_e'(kind);
    is_code       = seg_type[2];
    writable_data = !seg_type[2] && seg_type[0];
    readable_code = seg_type[0];
    absent        = !rights[RB_PRESENT];
    expand_down   = rights[RB_NONSYS] && (seg_type[2:1] == 2'b01);

    type_bad = 1'b0;
    if (!rights[RB_NONSYS]) begin
      type_bad = 1'b1;
    end else begin
      unique case (acc)
        ACC_READ:  type_bad = is_code && !readable_code;
        ACC_WRITE: type_bad = !writable_data;
        ACC_FETCH: type_bad = !is_code;
        default:   type_bad = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/seg_limit_eval.sv
module seg_limit_eval #(
  parameter int ADDR_W     = 32,
  parameter int LIMIT_W    = 20,
  parameter int GRAN_SHIFT = 12,
  parameter int SMALL_W    = 16
) (
  input  logic [LIMIT_W-1:0] limit_field,
  input  logic               gran,
  input  logic               big,
  input  logic               expand_down,
  input  logic [ADDR_W-1:0]  offset,
  output logic               limit_ok
);

  localparam logic [ADDR_W-1:0] GRAN_FILL = (ADDR_W'(1) << GRAN_SHIFT) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SMALL_TOP = (ADDR_W'(1) << SMALL_W) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] FULL_TOP  = '1;

  logic [ADDR_W-1:0] lim_ext;
  logic [ADDR_W-1:0] byte_limit;
  logic [ADDR_W-1:0] seg_top;
  logic              above_limit;

  always_comb begin
    lim_ext     = ADDR_W'(limit_field);
    byte_limit  = gran ? ((lim_ext << GRAN_SHIFT) | GRAN_FILL) : lim_ext;
    seg_top     = big ? FULL_TOP : SMALL_TOP;
    above_limit = offset > byte_limit;
    if (expand_down) limit_ok = above_limit && (offset <= seg_top);
    else             limit_ok = !above_limit;
  end

endmodule

// File: rtl/seg_result_reg.sv
module seg_result_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              drain,
  input  logic [1:0]        next_cause,
  input  logic [ADDR_W-1:0] next_addr,
  output logic              held,
  output logic [1:0]        cause,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= 1'b0;
      cause <= '0;
      addr  <= '0;
    end else begin
      if (take) begin
        held  <= 1'b1;
        cause <= next_cause;
        addr  <= next_addr;
      end else if (drain) begin
        held <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIMIT_W    = 20,
  parameter int GRAN_SHIFT = 12,
  parameter int SMALL_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_base,
  input  logic [LIMIT_W-1:0] in_limit,
  input  logic               in_gran,
  input  logic               in_big,
  input  logic [7:0]         in_rights,
  input  logic [ADDR_W-1:0]  in_offset,
  input  logic [1:0]         in_kind,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_fault,
  output logic [1:0]         out_cause,
  output logic [ADDR_W-1:0]  out_lin_addr
);

  logic              absent;
  logic              type_bad;
  logic              expand_down;
  logic              limit_ok;
  cause_e            cause_n;
  logic [ADDR_W-1:0] addr_n;
  logic              take;

  seg_rights_eval rights_i (
    .rights      (in_rights),
    .kind        (in_kind),
    .absent      (absent),
    .type_bad    (type_bad),
    .expand_down (expand_down)
  );

  seg_limit_eval #(
    .ADDR_W     (ADDR_W),
    .LIMIT_W    (LIMIT_W),
    .GRAN_SHIFT (GRAN_SHIFT),
    .SMALL_W    (SMALL_W)
  ) limit_i (
    .limit_field (in_limit),
    .gran        (in_gran),
    .big         (in_big),
    .expand_down (expand_down),
    .offset      (in_offset),
    .limit_ok    (limit_ok)
  );

  // fixed priority: absent, then type, then limit
  always_comb begin
    if (absent)         cause_n = CAUSE_ABSENT;
    else if (type_bad)  cause_n = CAUSE_TYPE;
    else if (!limit_ok) cause_n = CAUSE_LIMIT;
    else                cause_n = CAUSE_NONE;
    addr_n = (cause_n == CAUSE_NONE) ? (in_base + in_offset) : '0;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  seg_result_reg #(
    .ADDR_W (ADDR_W)
  ) result_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .drain      (out_ready),
    .next_cause (cause_n),
    .next_addr  (addr_n),
    .held       (out_valid),
    .cause      (out_cause),
    .addr       (out_lin_addr)
  );

  assign out_fault = (out_cause != 2'd0);

endmodule

// File: rtl/seg_access_check_chk.sv
module seg_access_check_chk #(
  parameter int ADDR_W  = 32,
  parameter int LIMIT_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [ADDR_W-1:0]  in_base,
  input logic [LIMIT_W-1:0] in_limit,
  input logic               in_gran,
  input logic               in_big,
  input logic [7:0]         in_rights,
  input logic [ADDR_W-1:0]  in_offset,
  input logic [1:0]         in_kind,
  input logic               out_valid,
  input logic               out_ready,
  input logic               out_fault,
  input logic [1:0]         out_cause,
  input logic [ADDR_W-1:0]  out_lin_addr
);

  // R1: accepted request shows up after the edge
  a_r1_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R1: ready follows the output state
  a_r1_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  // R2: stalled result holds
  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cause) && $stable(out_lin_addr)));

  // R8: absent descriptor reports cause 1
  a_r8_absent_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_rights[7]) |=> (out_cause == 2'd1));

  // R7: fetch from a present data or stack descriptor is a type fault
  a_r7_fetch_data: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_rights[7] && in_rights[4] && !in_rights[3] && in_kind == 2'd2)
    |=> (out_cause == 2'd2));

  // R11: fault flag, cause and address agree
  a_r11_fault_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault) |-> (out_cause != 2'd0 && out_lin_addr == '0));

  // R11: offset zero read of a normal data segment returns the base
  a_r11_zero_offset_base: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_rights[7] && in_rights[4] && in_rights[3:2] == 2'b00
     && in_kind == 2'd0 && in_offset == '0)
    |=> (!out_fault && out_lin_addr == $past(in_base)));

endmodule

bind seg_access_check seg_access_check_chk #(
  .ADDR_W  (ADDR_W),
  .LIMIT_W (LIMIT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_base      (in_base),
  .in_limit     (in_limit),
  .in_gran      (in_gran),
  .in_big       (in_big),
  .in_rights    (in_rights),
  .in_offset    (in_offset),
  .in_kind      (in_kind),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_fault    (out_fault),
  .out_cause    (out_cause),
  .out_lin_addr (out_lin_addr)
);

// File: tb/seg_access_check_tb_top.sv
`timescale 1ns/1ps
module seg_access_check_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_base = '0;
  logic [19:0] in_limit = '0;
  logic        in_gran = 1'b0;
  logic        in_big = 1'b0;
  logic [7:0]  in_rights = '0;
  logic [31:0] in_offset = '0;
  logic [1:0]  in_kind = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_fault;
  logic [1:0]  out_cause;
  logic [31:0] out_lin_addr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  seg_access_check dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_limit(in_limit), .in_gran(in_gran), .in_big(in_big),
    .in_rights(in_rights), .in_offset(in_offset), .in_kind(in_kind),
    .out_valid(out_valid), .out_ready(out_ready), .out_fault(out_fault),
    .out_cause(out_cause), .out_lin_addr(out_lin_addr)
  );

  // rights bytes: present, non-system, type t
  function automatic logic [7:0] rb(input int t);
    return 8'h90 | 8'(t << 1);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request; checks cause and address one cycle later
  task automatic access(input string tag, input logic [1:0] kind, input logic [31:0] base,
                        input logic [19:0] lim, input logic g, input logic d,
                        input logic [7:0] ar, input logic [31:0] off,
                        input logic [1:0] exp_cause, input logic [31:0] exp_addr);
    @(negedge clk);
    in_valid = 1'b1; in_kind = kind; in_base = base; in_limit = lim;
    in_gran = g; in_big = d; in_rights = ar; in_offset = off;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, 64'(out_valid), 64'd1);
    check({tag, " cause"}, 64'(out_cause), 64'(exp_cause));
    check({tag, " fault"}, 64'(out_fault), 64'(exp_cause != 2'd0));
    check({tag, " addr"}, 64'(out_lin_addr), 64'(exp_addr));
  endtask

  task automatic t_reset;
    check("R1 reset out_valid", 64'(out_valid), 64'd0);
    check("R1 reset in_ready", 64'(in_ready), 64'd1);
  endtask

  task automatic t_gran_small;
    access("R3 at limit", 2'd0, 32'h1000_0000, 20'h00FFF, 0, 0, rb(1), 32'hFFF, 2'd0, 32'h1000_0FFF);
    access("R3 past limit", 2'd0, 32'h1000_0000, 20'h00FFF, 0, 0, rb(1), 32'h1000, 2'd3, 0);
  endtask

  task automatic t_gran_big;
    access("R4 at limit", 2'd1, 32'h0002_0000, 20'h00001, 1, 0, rb(1), 32'h1FFF, 2'd0, 32'h0002_1FFF);
    access("R4 past limit", 2'd1, 32'h0002_0000, 20'h00001, 1, 0, rb(1), 32'h2000, 2'd3, 0);
    access("R11 wrap", 2'd0, 32'hFFFF_FF00, 20'hFFFFF, 1, 1, rb(1), 32'h200, 2'd0, 32'h0000_0100);
  endtask

  task automatic t_expand_down;
    access("R5 equal limit", 2'd1, 32'h5000, 20'h000FF, 0, 0, rb(3), 32'h00FF, 2'd3, 0);
    access("R5 above limit", 2'd1, 32'h5000, 20'h000FF, 0, 0, rb(3), 32'h0100, 2'd0, 32'h5100);
    access("R5 small top", 2'd0, 32'h5000, 20'h000FF, 0, 0, rb(3), 32'hFFFF, 2'd0, 32'h14FFF);
    access("R5 past small top", 2'd0, 32'h5000, 20'h000FF, 0, 0, rb(3), 32'h10000, 2'd3, 0);
    access("R5 big top mid", 2'd0, 32'h5000, 20'h000FF, 0, 1, rb(2), 32'h10000, 2'd0, 32'h15000);
    access("R5 big top end", 2'd0, 32'h0, 20'h000FF, 0, 1, rb(2), 32'hFFFF_FFFF, 2'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_rights;
    access("R6 write ro data", 2'd1, 32'h100, 20'hFFFFF, 0, 0, rb(0), 32'h4, 2'd2, 0);
    access("R6 write ro stack", 2'd1, 32'h100, 20'h00000, 0, 0, rb(2), 32'h40, 2'd2, 0);
    access("R6 write code", 2'd1, 32'h100, 20'hFFFFF, 0, 0, rb(5), 32'h4, 2'd2, 0);
    access("R7 read exec only", 2'd0, 32'h100, 20'hFFFFF, 0, 0, rb(4), 32'h4, 2'd2, 0);
    access("R7 read conf exec only", 2'd0, 32'h100, 20'hFFFFF, 0, 0, rb(6), 32'h4, 2'd2, 0);
    access("R7 read exec read", 2'd0, 32'h100, 20'hFFFFF, 0, 0, rb(7), 32'h4, 2'd0, 32'h104);
    access("R7 fetch data", 2'd2, 32'h100, 20'hFFFFF, 0, 0, rb(1), 32'h4, 2'd2, 0);
    access("R7 fetch code", 2'd2, 32'h100, 20'hFFFFF, 0, 0, rb(6), 32'h8, 2'd0, 32'h108);
  endtask

  task automatic t_absent_system;
    access("R8 absent read", 2'd0, 32'h100, 20'hFFFFF, 0, 0, 8'h12, 32'h4, 2'd1, 0);
    access("R9 system read", 2'd0, 32'h100, 20'hFFFFF, 0, 0, 8'h82, 32'h4, 2'd2, 0);
    access("R9 reserved kind", 2'd3, 32'h100, 20'hFFFFF, 0, 0, rb(1), 32'h4, 2'd2, 0);
  endtask

  task automatic t_priority;
    access("R10 absent over type+limit", 2'd2, 32'h100, 20'h00001, 0, 0, 8'h12, 32'hFF, 2'd1, 0);
    access("R10 type over limit", 2'd1, 32'h100, 20'h00001, 0, 0, rb(0), 32'hFF, 2'd2, 0);
  endtask

  task automatic t_stall;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_kind = 2'd0; in_base = 32'hA000; in_limit = 20'hFFFFF;
    in_gran = 0; in_big = 0; in_rights = rb(1); in_offset = 32'h10;
    @(negedge clk);
    check("R2 stall valid", 64'(out_valid), 64'd1);
    check("R2 stall ready low", 64'(in_ready), 64'd0);
    in_offset = 32'h20;
    @(negedge clk);
    check("R2 stall addr held", 64'(out_lin_addr), 64'h0000A010);
    check("R2 stall valid held", 64'(out_valid), 64'd1);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check("R1 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_gran_small();
    t_gran_big();
    t_expand_down();
    t_rights();
    t_absent_system();
    t_priority();
    t_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule